// File: doc/BRIEF.md
# Segmented Transfer DMA Sequencer

This block moves a run of bytes between a byte-wide memory port and a serial bus interface. The interface has a transmit FIFO, a receive FIFO and a status line that goes high once nothing is left to send. A transfer starts from a single command that gives a direction, a base address and a 32-bit byte count. Writes stream bytes from memory into the transmit FIFO. Reads push one filler byte (0xFF) into the transmit FIFO for each byte that should come back. The bytes that come back are stored at addresses that count up from the base.

A long transfer is broken into segments, and no segment is longer than a parameterised per-segment limit (4095 bytes by default). Each new segment is armed in a quiet cycle with no FIFO or memory traffic, and it starts at the base address plus the bytes already moved. A transfer shorter than a threshold (8 bytes) takes a one-byte-at-a-time path instead. On that path a byte must finish before the next one is issued. When the data is done, the block waits for the link to go idle, then pulses done. At that point it flushes the receive FIFO (for writes) or captures the sticky parity flag (for reads). An abort stops everything and clears the internal state.

Top module: `segx_dma_seq`

## Requirements
- R1: After reset, busy, done, tx_wr, rx_rd and mem_we are low. A start in idle with a nonzero count makes busy high from the next cycle.
- R2: No segment moves more than SEG_MAX bytes. Every segment except the last moves exactly SEG_MAX bytes. Across segment seams the memory addresses keep counting up from the base with no gap or repeat.
- R3: With a count below SHORT_LIM, at most one byte is outstanding on the link. A read waits for the received byte, and a write waits for link_idle, before the next push. With a count of SHORT_LIM or more, pushes continue while tx_full is low.
- R4: When dir_read=1, every byte pushed to tx_byte is 0xFF. The number of pushes equals the byte count.
- R5: When dir_read=1, receive byte i is written to address base_addr+i in arrival order. When dir_read=0, the byte at mem_raddr=base_addr+i is sent as the i-th pushed byte, and mem_we and rx_rd stay low.
- R6: done is raised only after every byte has moved and link_idle has been seen high.
- R7: At the completion of a write, rx_flush pulses for exactly one cycle, in the cycle before done rises. A read never asserts rx_flush.
- R8: At completion, xfer_err takes parity_sticky for a read and 0 for a write. It holds that value until the next accepted start.
- R9: done is a one-cycle pulse, and busy is low in the cycle where done is high.
- R10: A start while busy is ignored. The running transfer's addresses, data and count are unaffected.
- R11: A start with count 0 gives done in the next cycle with busy low. It causes no tx_wr, rx_rd or mem_we.
- R12: An abort while busy stops all FIFO and memory traffic from that cycle on. busy is low two cycles after abort is sampled, and no done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_read | input | 1 | 1: bus to memory, 0: memory to bus |
| base_addr | input | AW | First memory address |
| total_len | input | 32 | Byte count |
| abort | input | 1 | Stop the transfer in progress |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Parity flag captured at the end of a read |
| tx_wr | output | 1 | Push tx_byte into the transmit FIFO |
| tx_byte | output | 8 | Byte pushed (0xFF filler on reads) |
| tx_full | input | 1 | Transmit FIFO full |
| rx_rd | output | 1 | Pop the receive FIFO head |
| rx_byte | input | 8 | Receive FIFO head (first-word fall-through) |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_flush | output | 1 | Discard the receive FIFO contents |
| link_idle | input | 1 | Interface has nothing left to transmit |
| parity_sticky | input | 1 | Sticky receive parity error |
| mem_raddr | output | AW | Memory read address (combinational read) |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
Properties in the RTL hold on every cycle:
- done follows link_idle or a zero-length start, and is never two cycles long.
- A write never stores to memory.
- The short path never pushes in back-to-back cycles.
- The cycle after an abort is quiet.
- Inside a channel, the offset plus the bytes remaining stays constant while it moves data.
- Every non-final segment is exactly the limit.

Only the bench scenarios can show the end-to-end results. Those are data integrity across the 4095-byte seams, filler counts, the FIFO depth reached on each path, the flush leaving the receive side empty, the parity capture, and recovery after an abort.

// File: rtl/segx_dma_pkg.sv
`timescale 1ns/1ps
package segx_dma_pkg;

    parameter int CNT_W = 32;

    localparam logic [7:0] FILL_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_DRAIN,
        ST_ABORT
    } seq_state_e;

    typedef struct packed {
        logic rd;
        logic short_mode;
    } xfer_mode_t;

    function automatic logic [CNT_W-1:0] seg_clip(input logic [CNT_W-1:0] remain,
                                                  input logic [CNT_W-1:0] cap);
        return (remain > cap) ? cap : remain;
    endfunction

endpackage

// File: rtl/segx_dma_chan.sv
`timescale 1ns/1ps
module segx_dma_chan #(
    parameter int SEGW = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            clear,
    input  logic [SEGW-1:0] load_len,
    input  logic            enable,
    input  logic            gate,
    input  logic            ready,
    output logic            fire,
    output logic [SEGW-1:0] offset,
    output logic            drained
);

    logic [SEGW-1:0] left_q;
    logic [SEGW-1:0] off_q;

    assign drained = (left_q == '0);
    assign fire    = enable && gate && ready && !drained;
    assign offset  = off_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            left_q <= load_len;
            off_q  <= '0;
        end else if (fire) begin
            left_q <= left_q - 1'b1;
            off_q  <= off_q + 1'b1;
        end
    end

    // R2: moving a byte shifts one unit from remaining to offset, the span stays fixed
    a_r2_span_kept: assert property (@(posedge clk) disable iff (rst)
        fire |=> ((off_q + left_q) == $past(off_q + left_q)));

    // R12: a cleared channel is empty and idle afterwards
    a_r12_clear_empty: assert property (@(posedge clk) disable iff (rst)
        clear |=> (drained && !fire));

endmodule

// File: rtl/segx_dma_plan.sv
`timescale 1ns/1ps
module segx_dma_plan
    import segx_dma_pkg::*;
#(
    parameter int AW      = 16,
    parameter int SEG_MAX = 4095,
    parameter int SEGW    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] total,
    input  logic             advance,
    output logic [SEGW-1:0]  seg_len,
    output logic             last,
    output logic [AW-1:0]    moved_lo
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(SEG_MAX);

    logic [CNT_W-1:0] remain_q;
    logic [AW-1:0]    moved_q;

    assign seg_len  = SEGW'(seg_clip(remain_q, CAP));
    assign last     = (remain_q <= CAP);
    assign moved_lo = moved_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            remain_q <= '0;
            moved_q  <= '0;
        end else if (load) begin
            remain_q <= total;
            moved_q  <= '0;
        end else if (advance) begin
            remain_q <= remain_q - CNT_W'(seg_len);
            moved_q  <= moved_q + AW'(seg_len);
        end
    end

    // R2: a finished segment is never empty and never beyond the limit
    a_r2_seg_cap: assert property (@(posedge clk) disable iff (rst)
        advance |-> (seg_len != '0) && (seg_len <= SEGW'(SEG_MAX)));

    // R2: only the final segment may be shorter than the limit
    a_r2_full_inner: assert property (@(posedge clk) disable iff (rst)
        (advance && !last) |-> (seg_len == SEGW'(SEG_MAX)));

endmodule

// File: rtl/segx_dma_seq.sv
`timescale 1ns/1ps
module segx_dma_seq
    import segx_dma_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SEG_MAX   = 4095,
    parameter int SHORT_LIM = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir_read,
    input  logic [AW-1:0]    base_addr,
    input  logic [CNT_W-1:0] total_len,
    input  logic             abort,
    output logic             busy,
    output logic             done,
    output logic             xfer_err,
    output logic             tx_wr,
    output logic [7:0]       tx_byte,
    input  logic             tx_full,
    output logic             rx_rd,
    input  logic [7:0]       rx_byte,
    input  logic             rx_empty,
    output logic             rx_flush,
    input  logic             link_idle,
    input  logic             parity_sticky,
    output logic [AW-1:0]    mem_raddr,
    input  logic [7:0]       mem_rdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [7:0]       mem_wdata
);

    localparam int SEGW = $clog2(SEG_MAX + 1);

    seq_state_e      st_q, st_d;
    xfer_mode_t      mode_q;
    logic [AW-1:0]   base_q;
    logic            pend_q, done_q, err_q;

    logic            in_idle, accept, zero_len;
    logic            ch_load, ch_en, ch_clear, finish, seg_done;
    logic [SEGW-1:0] seg_len, rx_len, tx_off, rx_off;
    logic            last_seg, tx_fire, rx_fire, tx_drained, rx_drained;
    logic [AW-1:0]   moved_lo;

    assign in_idle  = (st_q == ST_IDLE);
    assign accept   = start && in_idle && !abort;
    assign zero_len = (total_len == '0);
    assign ch_load  = (st_q == ST_ARM);
    assign ch_en    = (st_q == ST_RUN) && !abort;
    assign ch_clear = (st_q == ST_ABORT);
    assign seg_done = ch_en && tx_drained && rx_drained && !pend_q;
    assign finish   = (st_q == ST_DRAIN) && link_idle && !abort;
    assign rx_len   = mode_q.rd ? seg_len : '0;

    segx_dma_plan #(.AW(AW), .SEG_MAX(SEG_MAX), .SEGW(SEGW)) u_plan (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && !zero_len),
        .clear    (ch_clear),
        .total    (total_len),
        .advance  (seg_done),
        .seg_len  (seg_len),
        .last     (last_seg),
        .moved_lo (moved_lo)
    );

    segx_dma_chan #(.SEGW(SEGW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (ch_load),
        .clear    (ch_clear),
        .load_len (seg_len),
        .enable   (ch_en),
        .gate     (!mode_q.short_mode || !pend_q),
        .ready    (!tx_full),
        .fire     (tx_fire),
        .offset   (tx_off),
        .drained  (tx_drained)
    );

    segx_dma_chan #(.SEGW(SEGW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .load     (ch_load),
        .clear    (ch_clear),
        .load_len (rx_len),
        .enable   (ch_en),
        .gate     (1'b1),
        .ready    (!rx_empty),
        .fire     (rx_fire),
        .offset   (rx_off),
        .drained  (rx_drained)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (accept && !zero_len) st_d = ST_ARM;
            ST_ARM:   st_d = ST_RUN;
            ST_RUN:   if (seg_done) st_d = last_seg ? ST_DRAIN : ST_ARM;
            ST_DRAIN: if (link_idle) st_d = ST_IDLE;
            ST_ABORT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
        if (abort && !in_idle && (st_q != ST_ABORT)) st_d = ST_ABORT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= '0;
            base_q <= '0;
            pend_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (accept && zero_len) || finish;
            if (accept) begin
                mode_q.rd         <= dir_read;
                mode_q.short_mode <= (total_len < CNT_W'(SHORT_LIM));
                base_q            <= base_addr;
                err_q             <= 1'b0;
            end else if (abort && !in_idle) begin
                mode_q <= '0;
                base_q <= '0;
            end
            if (finish) err_q <= mode_q.rd && parity_sticky;
            if (!ch_en)
                pend_q <= 1'b0;
            else if (tx_fire && mode_q.short_mode)
                pend_q <= 1'b1;
            else if (pend_q && (mode_q.rd ? rx_fire : link_idle))
                pend_q <= 1'b0;
        end
    end

    assign busy      = !in_idle;
    assign done      = done_q;
    assign xfer_err  = err_q;
    assign tx_wr     = tx_fire;
    assign tx_byte   = mode_q.rd ? FILL_BYTE : mem_rdata;
    assign rx_rd     = rx_fire;
    assign rx_flush  = finish && !mode_q.rd;
    assign mem_raddr = base_q + moved_lo + AW'(tx_off);
    assign mem_we    = rx_fire;
    assign mem_waddr = base_q + moved_lo + AW'(rx_off);
    assign mem_wdata = rx_byte;

    // R9: completion pulse lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion only after the link was seen idle (or a zero-length start)
    a_r6_done_link: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(link_idle) || $past(start)));

    // R12: no traffic in the cycle after an abort of a busy transfer
    a_r12_abort_quiet: assert property (@(posedge clk) disable iff (rst)
        ($past(abort) && $past(busy)) |-> (!tx_wr && !rx_rd && !mem_we));

    // R3: byte mode never pushes in two consecutive cycles
    a_r3_byte_spacing: assert property (@(posedge clk) disable iff (rst)
        (mode_q.short_mode && $past(tx_wr)) |-> !tx_wr);

    // R5: a write transfer never stores to memory or pops the receive side
    a_r5_write_no_store: assert property (@(posedge clk) disable iff (rst)
        (busy && !mode_q.rd) |-> (!mem_we && !rx_rd));

    // R10: a start while busy leaves the latched base untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !abort && (st_q != ST_ABORT)) |=> $stable(base_q));

    // R11: a zero-length start completes at once and stays idle
    a_r11_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start && in_idle && !abort && zero_len) |=> (done && !busy));

endmodule

// File: tb/segx_dma_seq_test.sv
`timescale 1ns/1ps
module segx_dma_seq_test;
    import segx_dma_pkg::*;

    localparam int AW = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic start = 1'b0, dir_read = 1'b0, abort = 1'b0, parity_sticky = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CNT_W-1:0] total_len = '0;
    logic busy, done, xfer_err, tx_wr, rx_rd, rx_flush, mem_we;
    logic tx_full, rx_empty, link_idle;
    logic [7:0] tx_byte, rx_byte, mem_rdata, mem_wdata;
    logic [AW-1:0] mem_raddr, mem_waddr;

    segx_dma_seq uut (
        .clk(clk), .rst(rst), .start(start), .dir_read(dir_read),
        .base_addr(base_addr), .total_len(total_len), .abort(abort),
        .busy(busy), .done(done), .xfer_err(xfer_err),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_full(tx_full),
        .rx_rd(rx_rd), .rx_byte(rx_byte), .rx_empty(rx_empty),
        .rx_flush(rx_flush), .link_idle(link_idle), .parity_sticky(parity_sticky),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // ---------------- bus interface and memory model ----------------
    logic [7:0] mem [0:65535];
    logic [7:0] rxbuf [0:15];
    int tx_cnt, tmr, wp, rp, rx_gen, maxd;
    logic bclr = 1'b0, maxd_clr = 1'b0;
    logic pop_w;

    function automatic logic [7:0] rx_pat(int n);
        return 8'(n * 37 + 11);
    endfunction

    assign pop_w     = (tx_cnt > 0) && (tmr == 2);
    assign tx_full   = (tx_cnt >= 4);
    assign link_idle = (tx_cnt == 0);
    assign rx_empty  = (wp == rp);
    assign rx_byte   = rxbuf[rp[3:0]];
    assign mem_rdata = mem[mem_raddr];

    always @(posedge clk) begin
        if (rst) begin
            tx_cnt <= 0; tmr <= 0; wp <= 0; rp <= 0; rx_gen <= 0; maxd <= 0;
            for (int i = 0; i < 65536; i++) mem[i] <= 8'(i * 13 ^ (i >> 8));
        end else begin
            tx_cnt <= tx_cnt + (tx_wr ? 1 : 0) - (pop_w ? 1 : 0);
            tmr    <= (tx_cnt > 0 && tmr != 2) ? tmr + 1 : 0;
            if (pop_w) begin
                rxbuf[wp[3:0]] <= rx_pat(rx_gen);
                wp     <= wp + 1;
                rx_gen <= rx_gen + 1;
            end
            if (bclr || rx_flush) rp <= wp;
            else if (rx_rd) rp <= rp + 1;
            if (maxd_clr) maxd <= 0;
            else if (tx_cnt > maxd) maxd <= tx_cnt;
            if (mem_we) mem[mem_waddr] <= mem_wdata;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;
    int act_cnt = 0, fill_cnt = 0, flush_cnt = 0, done_cnt = 0;
    logic cur_rd = 1'b0;
    logic [23:0] sb [$];

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as the design produces bytes
    always @(negedge clk) begin
        logic [23:0] it;
        if (!rst) begin
            if (tx_wr || rx_rd || mem_we) act_cnt++;
            if (rx_flush) flush_cnt++;
            if (done) done_cnt++;
            if (tx_wr && cur_rd) begin
                fill_cnt++;
                chk("R4", "filler byte", tx_byte, 8'hFF);
            end
            if ((tx_wr && !cur_rd) || mem_we) begin
                if (sb.size() == 0) begin
                    chk("R5", "unexpected transfer byte", 1, 0);
                end else begin
                    it = sb.pop_front();
                    if (mem_we)
                        chk("R5 R2", "stored addr/data", {mem_waddr, mem_wdata}, it);
                    else
                        chk("R5 R2", "sent addr/data", {mem_raddr, tx_byte}, it);
                end
            end
        end
    end

    // driver: loads expectations, starts, waits, checks completion
    task automatic run_xfer(bit rd, int base, int len, bit par, int depth_mode, bit inject);
        int fl0, waited;
        cur_rd = rd;
        parity_sticky = par;
        for (int i = 0; i < len; i++) begin
            if (rd) sb.push_back({16'(base + i), rx_pat(rx_gen + i)});
            else    sb.push_back({16'(base + i), mem[16'(base + i)]});
        end
        fill_cnt = 0;
        fl0 = flush_cnt;
        maxd_clr = 1'b1;
        @(negedge clk);
        maxd_clr = 1'b0;
        start = 1'b1; dir_read = rd; base_addr = 16'(base); total_len = 32'(len);
        @(negedge clk);
        start = 1'b0;
        chk("R1", "busy after start", busy, 1);
        waited = 0;
        while (!done && waited < 40000) begin
            @(negedge clk);
            waited++;
            if (inject && waited == 20) begin
                start = 1'b1; dir_read = !rd; base_addr = 16'h0300; total_len = 32'd3;
                @(negedge clk);
                start = 1'b0;
                chk("R10", "busy kept after stray start", busy, 1);
            end
        end
        chk("R6", "done reached", done, 1);
        chk("R6", "link idle at done", link_idle, 1);
        chk("R9", "busy low with done", busy, 0);
        chk("R5", "scoreboard drained", sb.size(), 0);
        if (rd) chk("R4", "filler count", fill_cnt, len);
        chk("R8", "error capture", xfer_err, rd ? par : 1'b0);
        chk("R7", "flush pulses", flush_cnt - fl0, rd ? 0 : 1);
        if (!rd) chk("R7", "rx empty after flush", rx_empty, 1);
        if (depth_mode == 1) chk("R3", "byte mode depth", maxd, 1);
        if (depth_mode == 2) chk("R3", "segmented mode fills fifo", maxd > 1, 1);
        @(negedge clk);
        chk("R9", "done one cycle", done, 0);
        chk("R8", "error held", xfer_err, rd ? par : 1'b0);
    endtask

    initial begin
        int a0, d0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset traffic", {tx_wr, rx_rd, mem_we}, 0);

        // R11 zero-length
        a0 = act_cnt;
        start = 1'b1; dir_read = 1'b0; base_addr = 16'h0040; total_len = '0;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "zero length done", done, 1);
        chk("R11", "zero length busy", busy, 0);
        @(negedge clk);
        chk("R11", "zero length pulse", done, 0);
        chk("R11", "zero length traffic", act_cnt - a0, 0);

        run_xfer(1'b0, 16'h8000, 5,    1'b1, 1, 1'b0); // R3 byte-mode write
        run_xfer(1'b1, 16'h4000, 7,    1'b0, 1, 1'b0); // R3 byte-mode read
        run_xfer(1'b1, 16'h4100, 8,    1'b1, 2, 1'b0); // R3 threshold
        run_xfer(1'b0, 16'hA000, 600,  1'b0, 2, 1'b1); // R10 stray start
        run_xfer(1'b1, 16'h1000, 9000, 1'b1, 0, 1'b0); // R2 read seams
        run_xfer(1'b0, 16'h8100, 4096, 1'b0, 0, 1'b0); // R2 write seam

        // R12 abort
        cur_rd = 1'b1;
        for (int i = 0; i < 200; i++) sb.push_back({16'(16'h6000 + i), rx_pat(rx_gen + i)});
        start = 1'b1; dir_read = 1'b1; base_addr = 16'h6000; total_len = 32'd200;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R12", "quiet after abort", {tx_wr, rx_rd, mem_we}, 0);
        @(negedge clk);
        chk("R12", "busy dropped", busy, 0);
        a0 = act_cnt; d0 = done_cnt;
        repeat (30) @(negedge clk);
        chk("R12", "no traffic after abort", act_cnt - a0, 0);
        chk("R12", "no done after abort", done_cnt - d0, 0);
        sb.delete();
        bclr = 1'b1;
        @(negedge clk);
        bclr = 1'b0;
        run_xfer(1'b1, 16'h5000, 20, 1'b0, 2, 1'b0); // R12 recovery

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule